// File: doc/BRIEF.md
# USB Endpoint Event and Mask Aggregator

This block keeps the per-FIFO event flags of a small USB function controller together with their enable masks, and boils them down to two summary flags, `rx_ev` and `tx_ev`, which feed the controller's top-level event register. Packet-engine pulses set the flags. Firmware reads and writes four 8-bit registers over a simple strobe bus.

Receive flags clear in two different ways. A per-FIFO completion flag is cleared only when firmware reads that FIFO's receive status register, which lives outside this block and reaches it as a read strobe. The overrun flags are all cleared by reading the receive event register itself. The control endpoint, FIFO 0, ignores a completion that carries only an error, so a corrupted setup packet never raises an event.

Transmit completion flags follow the same per-FIFO scheme. Each one clears when the strobe from that FIFO's transmit status read arrives.

Top module: `usb_evt_aggr`

## Requirements
- R1: After a synchronous active-low reset, all four registers read 0x00 and `rx_ev` and `tx_ev` are 0.
- R2: Receive event register (address 0), bit n for n in 1..3, is set by a `rx_last[n]` or a `rx_err[n]` pulse.
- R3: For FIFO 0, bit 0 of address 0 is set only by `rx_last[0]`. A `rx_err[0]` pulse without `rx_last[0]` leaves it unchanged.
- R4: Bit n (n in 0..3) of address 0 is cleared by a `rxs_rd[n]` strobe. Reading address 0 does not clear it.
- R5: Bit 4+n of address 0 is set by `rx_ovr[n]`. All four overrun bits clear together on an edge where `reg_rd` is high with `reg_addr` = 0. A read of any other address leaves them.
- R6: When a set pulse and a clearing strobe or read hit the same event bit on the same edge, the bit ends up set.
- R7: The receive mask at address 1 is read/write with the same layout as address 0. `rx_ev` is 1 when any bit of address 0 AND its mask bit is 1.
- R8: Transmit event register (address 2): bit n (0..3) is set by `tx_done[n]` and cleared by `txs_rd[n]`. Bits 7..4 read 0. Reading it has no side effect.
- R9: The transmit mask at address 3 is read/write in bits 3..0, and bits 7..4 read 0. `tx_ev` is 1 when any transmit event bit AND its mask bit is 1.
- R10: Writes to address 0 and address 2 change nothing.
- R11: `rx_ev` and `tx_ev` are registered. A change of event or mask bits made on edge k shows on the summary flags after edge k+1.
- R12: `reg_rdata` shows the addressed register while `reg_rd` is 1 and is 0x00 otherwise. The value returned is the one from before that edge's clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_last | input | 4 | Per-FIFO receive packet-complete pulse |
| rx_err | input | 4 | Per-FIFO receive error pulse |
| rx_ovr | input | 4 | Per-FIFO receive overrun pulse |
| tx_done | input | 4 | Per-FIFO transmit-complete pulse |
| rxs_rd | input | 4 | Per-FIFO receive status register read strobe |
| txs_rd | input | 4 | Per-FIFO transmit status register read strobe |
| reg_addr | input | 2 | Register select: 0 rx event, 1 rx mask, 2 tx event, 3 tx mask |
| reg_rd | input | 1 | Register read strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| rx_ev | output | 1 | Registered receive summary flag |
| tx_ev | output | 1 | Registered transmit summary flag |

## Verification
The main function is driven with several patterns:
- A completion pulse with and without an error on FIFO 0, which separates the control-endpoint rule from the rule for the other FIFOs.
- An overrun followed by reads of the mask register and then the event register, which shows which read clears which bits.
- A completion and its clearing status strobe on the same edge, which shows that the set wins.

Mask patterns that cover and then uncover a pending bit show that the summary is gated by the mask and not by the event alone. A one-cycle sampling sequence confirms that the summary flags lag by one edge.

// File: rtl/usb_evt_pkg.sv
// Shared definitions for the endpoint event aggregator.
// Assumes a 2-bit register select and a register width of twice the FIFO count.
package usb_evt_pkg;

    // Register select codes on the firmware bus
    typedef enum logic [1:0] {
        ADR_RX_EVT = 2'd0,
        ADR_RX_MSK = 2'd1,
        ADR_TX_EVT = 2'd2,
        ADR_TX_MSK = 2'd3
    } evt_addr_e;

endpackage

// File: rtl/usb_rx_evt_bank.sv
// Receive event flags: per-FIFO completion flags in the low half and overrun
// flags in the high half. A completion flag clears on its status read strobe.
// All overrun flags clear on a qualified read of the event register. A set on
// the same edge always wins. The control FIFO ignores error-only completions.
// Assumes the pulses are one cycle wide and synchronous to clk.
module usb_rx_evt_bank #(
    parameter int NFIFO    = 4,
    parameter int CTRL_IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NFIFO-1:0]     pkt_last,
    input  logic [NFIFO-1:0]     pkt_err,
    input  logic [NFIFO-1:0]     ovr,
    input  logic [NFIFO-1:0]     stat_rd,
    input  logic                 evt_rd,
    output logic [2*NFIFO-1:0]   evt_q
);

    logic [NFIFO-1:0] cmp_set;
    logic [NFIFO-1:0] cmp_q;
    logic [NFIFO-1:0] ovr_q;

    // Per-FIFO set condition; the control FIFO takes only clean completions
    for (genvar i = 0; i < NFIFO; i++) begin : g_set
        if (i == CTRL_IDX) begin : g_ctrl
            assign cmp_set[i] = pkt_last[i];
        end else begin : g_data
            assign cmp_set[i] = pkt_last[i] | pkt_err[i];
        end
    end

    // Completion flags: set has priority over the status-read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            cmp_q <= cmp_set | (cmp_q & ~stat_rd);
        end
    end

    // Overrun flags: set has priority over the event-register read clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= '0;
        end else begin
            ovr_q <= ovr | (ovr_q & ~{NFIFO{evt_rd}});
        end
    end

    assign evt_q = {ovr_q, cmp_q};

endmodule

// File: rtl/usb_tx_evt_bank.sv
// Transmit completion flags, one per FIFO. A flag is set by a done pulse and
// cleared by the matching transmit status read strobe; the set wins on a tie.
// Assumes one-cycle pulses synchronous to clk.
module usb_tx_evt_bank #(
    parameter int NFIFO = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFIFO-1:0] done,
    input  logic [NFIFO-1:0] stat_rd,
    output logic [NFIFO-1:0] evt_q
);

    // Completion flags with set-over-clear priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= done | (evt_q & ~stat_rd);
        end
    end

endmodule

// File: rtl/usb_evt_mask_reg.sv
// Plain firmware-writable mask register of parameterised width.
// Assumes the write enable is already qualified by address.
module usb_evt_mask_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] q
);

    // Load on a qualified write, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/usb_evt_summary.sv
// Registered OR-reduction of event bits gated by their mask bits.
// The flag follows the inputs with one cycle of latency.
module usb_evt_summary #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] evt,
    input  logic [WIDTH-1:0] msk,
    output logic             flag
);

    logic any_hit;

    // Any enabled event pending
    assign any_hit = |(evt & msk);

    // Register the summary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else begin
            flag <= any_hit;
        end
    end

endmodule

// File: rtl/usb_evt_aggr.sv
// Endpoint event and mask aggregator top. Decodes the 2-bit register bus,
// keeps the receive and transmit event and mask registers, and drives the
// registered summary flags. Read data is combinational and returns each
// register's value from before the current edge's clear-on-read.
// Assumes DATA_W is even; the FIFO count is half the register width.
module usb_evt_aggr
    import usb_evt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DATA_W/2-1:0]     rx_last,
    input  logic [DATA_W/2-1:0]     rx_err,
    input  logic [DATA_W/2-1:0]     rx_ovr,
    input  logic [DATA_W/2-1:0]     tx_done,
    input  logic [DATA_W/2-1:0]     rxs_rd,
    input  logic [DATA_W/2-1:0]     txs_rd,
    input  logic [1:0]              reg_addr,
    input  logic                    reg_rd,
    input  logic                    reg_wr,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    rx_ev,
    output logic                    tx_ev
);

    localparam int NFIFO = DATA_W / 2;
    localparam int PADW  = DATA_W - NFIFO;

    logic              rd_rx_evt;
    logic              we_rx_msk;
    logic              we_tx_msk;
    logic [DATA_W-1:0] rx_evt;
    logic [DATA_W-1:0] rx_msk;
    logic [NFIFO-1:0]  tx_evt;
    logic [NFIFO-1:0]  tx_msk;

    // Qualified strobes; only exact-address accesses have side effects
    assign rd_rx_evt = reg_rd && (reg_addr == ADR_RX_EVT);
    assign we_rx_msk = reg_wr && (reg_addr == ADR_RX_MSK);
    assign we_tx_msk = reg_wr && (reg_addr == ADR_TX_MSK);

    usb_rx_evt_bank #(
        .NFIFO    (NFIFO),
        .CTRL_IDX (0)
    ) rx_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pkt_last (rx_last),
        .pkt_err  (rx_err),
        .ovr      (rx_ovr),
        .stat_rd  (rxs_rd),
        .evt_rd   (rd_rx_evt),
        .evt_q    (rx_evt)
    );

    usb_tx_evt_bank #(
        .NFIFO   (NFIFO)
    ) tx_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (tx_done),
        .stat_rd (txs_rd),
        .evt_q   (tx_evt)
    );

    usb_evt_mask_reg #(
        .WIDTH (DATA_W)
    ) rx_msk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_rx_msk),
        .wdata (reg_wdata),
        .q     (rx_msk)
    );

    usb_evt_mask_reg #(
        .WIDTH (NFIFO)
    ) tx_msk_i (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we_tx_msk),
        .wdata (reg_wdata[NFIFO-1:0]),
        .q     (tx_msk)
    );

    usb_evt_summary #(
        .WIDTH (DATA_W)
    ) rx_sum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (rx_evt),
        .msk   (rx_msk),
        .flag  (rx_ev)
    );

    usb_evt_summary #(
        .WIDTH (NFIFO)
    ) tx_sum_i (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (tx_evt),
        .msk   (tx_msk),
        .flag  (tx_ev)
    );

    // Read multiplexer; zero when no read is in progress
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            case (reg_addr)
                ADR_RX_EVT: reg_rdata = rx_evt;
                ADR_RX_MSK: reg_rdata = rx_msk;
                ADR_TX_EVT: reg_rdata = {{PADW{1'b0}}, tx_evt};
                default:    reg_rdata = {{PADW{1'b0}}, tx_msk};
            endcase
        end
    end

endmodule

// File: rtl/usb_evt_aggr_chk.sv
// Property checker for the aggregator, attached by bind below.
module usb_evt_aggr_chk #(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [DATA_W/2-1:0] rx_last,
    input logic [DATA_W/2-1:0] rx_err,
    input logic [DATA_W/2-1:0] rx_ovr,
    input logic [DATA_W/2-1:0] rxs_rd,
    input logic [1:0]          reg_addr,
    input logic                reg_rd,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic                rx_ev,
    input logic [DATA_W-1:0]   rx_evt,
    input logic [DATA_W-1:0]   rx_msk
);

    localparam int NFIFO = DATA_W / 2;

    // R3
    ctrl_err_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_evt[0] && rx_err[0] && !rx_last[0]) |=> !rx_evt[0]);

    // R5
    ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd0 && rx_ovr == '0) |=> (rx_evt[DATA_W-1:NFIFO] == '0));

    // R6
    for (genvar i = 0; i < NFIFO; i++) begin : g_tie
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_last[i] && rxs_rd[i]) |=> rx_evt[i]);
    end

    // R10
    evt_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && reg_addr == 2'd0 && rx_last == '0 && rx_err == '0
         && rx_ovr == '0 && rxs_rd == '0) |=> (rx_evt == $past(rx_evt)));

    // R11
    rx_sum_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ev == $past(|(rx_evt & rx_msk)));

    // R12
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> (reg_rdata == '0));

endmodule

bind usb_evt_aggr usb_evt_aggr_chk #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_last   (rx_last),
    .rx_err    (rx_err),
    .rx_ovr    (rx_ovr),
    .rxs_rd    (rxs_rd),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .rx_ev     (rx_ev),
    .rx_evt    (rx_evt),
    .rx_msk    (rx_msk)
);

// File: tb/usb_evt_aggr_tb_top.sv
// Self-checking bench: vector table walk, then directed reset and corner cases.
module usb_evt_aggr_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] rx_last = '0, rx_err = '0, rx_ovr = '0, tx_done = '0;
    logic [3:0] rxs_rd = '0, txs_rd = '0;
    logic [1:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_ev, tx_ev;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    usb_evt_aggr dut_i (
        .clk(clk), .rst_n(rst_n), .rx_last(rx_last), .rx_err(rx_err),
        .rx_ovr(rx_ovr), .tx_done(tx_done), .rxs_rd(rxs_rd), .txs_rd(txs_rd),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_ev(rx_ev), .tx_ev(tx_ev)
    );

    typedef struct packed {
        logic [3:0] last, err, ovr, done, rxs, txs;
        logic       wr, rd;
        logic [1:0] addr;
        logic [7:0] wdata, exp_rd;
        logic       exp_rx, exp_tx;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd1,8'hFF,8'h00,1'b0,1'b0,4'd7},  // R7 rx mask all on
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd3,8'h0F,8'h00,1'b0,1'b0,4'd9},  // R9 tx mask
        '{4'h1,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,4'd3},  // R3 clean ctrl completion
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h01,1'b1,1'b0,4'd4},  // R4 read keeps bit 0
        '{4'h0,4'h0,4'h0,4'h0,4'h1,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,4'd4},  // R4 status read clears
        '{4'h0,4'h1,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,4'd3},  // R3 error-only ignored
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,4'd3},  // R3 readback
        '{4'h0,4'h4,4'h0,4'h0,4'h0,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,4'd2},  // R2 error on FIFO 2
        '{4'h0,4'h0,4'h8,4'h0,4'h0,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,4'd5},  // R5 overrun FIFO 3
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd1,8'h00,8'hFF,1'b1,1'b0,4'd5},  // R5 mask read no clear
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h84,1'b1,1'b0,4'd5},  // R5 read shows, clears
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h04,1'b1,1'b0,4'd5},  // R5 overrun gone
        '{4'h4,4'h0,4'h0,4'h0,4'h4,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b1,1'b0,4'd6},  // R6 set beats clear
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd1,8'h00,8'h00,1'b0,1'b0,4'd7},  // R7 mask off
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h04,1'b0,1'b0,4'd6},  // R6 bit survived
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd0,8'hFF,8'h00,1'b0,1'b0,4'd10}, // R10 write rx event
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h04,1'b0,1'b0,4'd10}, // R10 unchanged
        '{4'h0,4'h0,4'h0,4'h2,4'h0,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b1,4'd8},  // R8 tx done FIFO 1
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd2,8'h00,8'h02,1'b0,1'b1,4'd8},  // R8 read no clear
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd3,8'h0D,8'h00,1'b0,1'b0,4'd9},  // R9 mask blocks bit 1
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd3,8'h00,8'h0D,1'b0,1'b0,4'd9},  // R9 readback
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd2,8'hFF,8'h00,1'b0,1'b0,4'd10}, // R10 write tx event
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd2,8'h00,8'h02,1'b0,1'b0,4'd10}, // R10 unchanged
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h2,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,4'd8},  // R8 status read clears
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b1,1'b0,2'd3,8'hFF,8'h00,1'b0,1'b0,4'd9},  // R9 upper bits dropped
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd3,8'h00,8'h0F,1'b0,1'b0,4'd9},  // R9 readback
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd2,8'h00,8'h00,1'b0,1'b0,4'd8},  // R8 cleared
        '{4'h0,4'h0,4'h0,4'h0,4'h4,4'h0,1'b0,1'b0,2'd0,8'h00,8'h00,1'b0,1'b0,4'd4},  // R4 clear FIFO 2
        '{4'h0,4'h0,4'h0,4'h0,4'h0,4'h0,1'b0,1'b1,2'd0,8'h00,8'h00,1'b0,1'b0,4'd4}   // R4 readback
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_last = '0; rx_err = '0; rx_ovr = '0; tx_done = '0;
        rxs_rd = '0; txs_rd = '0; reg_rd = 1'b0; reg_wr = 1'b0;
        reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    // One-cycle read with combinational data check
    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); idle(); reg_rd = 1'b1; reg_addr = a;
        #2 chk(req, reg_rdata, exp);
        @(negedge clk); idle();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); idle(); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); idle();
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 rx_ev", {7'd0, rx_ev}, 8'h00);
        chk("R1 tx_ev", {7'd0, tx_ev}, 8'h00);
        for (int a = 0; a < 4; a++) rd(a[1:0], 8'h00, "R1 reg");

        // Table walk: stimulus cycle, then idle cycle, then summary check
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            rx_last = VEC[v].last; rx_err = VEC[v].err; rx_ovr = VEC[v].ovr;
            tx_done = VEC[v].done; rxs_rd = VEC[v].rxs; txs_rd = VEC[v].txs;
            reg_wr = VEC[v].wr; reg_rd = VEC[v].rd; reg_addr = VEC[v].addr;
            reg_wdata = VEC[v].wdata;
            #2 chk($sformatf("R%0d/R12 rdata v%0d", VEC[v].req, v), reg_rdata, VEC[v].exp_rd);
            @(negedge clk); idle();
            @(negedge clk);
            chk($sformatf("R%0d rx_ev v%0d", VEC[v].req, v), {7'd0, rx_ev}, {7'd0, VEC[v].exp_rx});
            chk($sformatf("R%0d tx_ev v%0d", VEC[v].req, v), {7'd0, tx_ev}, {7'd0, VEC[v].exp_tx});
        end

        // R11 one-edge lag of the summary flag
        do_reset();
        wr(2'd1, 8'h02);
        @(negedge clk); rx_last = 4'h2;
        @(negedge clk); idle();
        chk("R11 rx_ev before lag", {7'd0, rx_ev}, 8'h00);
        @(negedge clk);
        chk("R11 rx_ev after lag", {7'd0, rx_ev}, 8'h01);

        // R2 error and completion on two data FIFOs at once
        @(negedge clk); rx_err = 4'h2; rx_last = 4'h8;
        @(negedge clk); idle();
        rd(2'd0, 8'h0A, "R2 both set");

        // R6 overrun and event-register read on the same edge
        @(negedge clk); idle(); rx_ovr = 4'h8; reg_rd = 1'b1; reg_addr = 2'd0;
        #2 chk("R6 pre-edge rdata", reg_rdata, 8'h0A);
        @(negedge clk); idle();
        rd(2'd0, 8'h8A, "R6 overrun kept");
        rd(2'd0, 8'h0A, "R5 overrun cleared");

        // R1 reset in mid-run clears everything
        wr(2'd3, 8'h0F);
        @(negedge clk); tx_done = 4'hF;
        @(negedge clk); idle();
        do_reset();
        chk("R1 rx_ev mid", {7'd0, rx_ev}, 8'h00);
        chk("R1 tx_ev mid", {7'd0, tx_ev}, 8'h00);
        for (int a = 0; a < 4; a++) rd(a[1:0], 8'h00, "R1 reg mid");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule